// File: doc/BRIEF.md
# Byte-Granular Register Write-Lock Guard

This block sits on the bus in front of a small bank of byte-wide module registers and decides, byte by byte, whether a write may land. Every register byte owns one sticky lock bit. Once that bit is set, data writes to the byte are refused until the next reset. Lock bits are grouped four to a lock byte. Software sets them in one of two ways. It can write a lock byte directly, with a write-enable nibble choosing which bits may change. It can also write the data registers through a mirror window, which stores the data and locks each protected byte it touched.

Each byte has a protection class fixed at build time: unprotected, byte, halfword or word. The class decides how a lock-bit write is interpreted. In a halfword pair, or in a word group, the lowest member speaks for the whole group. An unprotected byte can never become locked. Reads return register contents through either data window, and lock contents at the lock window. Read data and the response flags come one cycle after the request.

Top module: `wlock_guard`

## Requirements
- R1: After reset every data byte and every lock bit reads 0, and `ack` and `err` are 0 until a request arrives.
- R2: A request with `req`=1 gets `ack`=1 on the next cycle, with `err` and `rdata` valid in that same cycle. `size` 0/1/2 selects an 8/16/32-bit access. The byte at address a travels on `wdata`/`rdata` bits [8*(a mod 4)+7 : 8*(a mod 4)]. Read lanes outside the access return 0.
- R3: Data window bytes 0..NB-1 sit at offsets 0..NB-1. A write there updates the unlocked bytes it covers and leaves every lock bit unchanged.
- R4: The mirror window at MIRROR_BASE+offset reaches the same bytes. A write there also sets the lock bit of every covered byte whose class is not unprotected. Unprotected bytes are written but stay unlocked.
- R5: Lock byte j sits at LOCK_BASE+j and governs data bytes 4j..4j+3, with bit b standing for byte 4j+b. A written lock byte carries lock data in bits [3:0] and write enables in bits [7:4]. A read returns {4'b0, lock bits}.
- R6: For a byte-class bit b, a direct lock write sets bit b when written WE[b]=1 and data[b]=1.
- R7: For halfword-class bits, pairs (0,1) and (2,3) both take the enable and data of the pair's lower bit. The upper bit's own written enable and data are ignored.
- R8: For word-class bits, all four bits take the enable and data of bit 0.
- R9: An unprotected-class lock bit stays 0 under any direct or mirror write.
- R10: No write through any window can clear a set lock bit. Only reset clears it.
- R11: A data write (normal or mirror) covering a locked byte leaves that byte unchanged and returns `err`=1. Unlocked bytes in the same access are still written.
- R12: A misaligned access (16-bit on an odd address, 32-bit not on a multiple of 4), `size`=3, or any covered byte outside the three windows returns `err`=1 and changes no state. Such a read returns `rdata`=0.
- R13: A read through the mirror window returns the same data as the same read through the data window.

The default build has NB=16, MIRROR_BASE=0x2000 and LOCK_BASE=0x1000. Classes come from PROT, two bits per byte k at [2k+1:2k], coded 0 none, 1 byte, 2 halfword, 3 word. The default PROT=0x4AAAFF55 makes lock byte 0 byte-class and lock byte 1 word-class. Lock byte 2 is halfword-class. Lock byte 3 has bits 0/1 halfword, bit 2 unprotected and bit 3 byte-class.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Access request, one cycle per access |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | AW | Byte address of the access |
| size | input | 2 | 0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = invalid |
| wdata | input | 32 | Write data, lane by address |
| ack | output | 1 | Registered completion, one cycle after `req` |
| err | output | 1 | Registered error flag for the completed access |
| rdata | output | 32 | Registered read data |

## Verification
The hardest behaviour to reach from the ports is the way direct lock writes are interpreted across protection classes. Lock bits are sticky, so a single run saturates after a few writes and cannot show how every enable/data combination is decoded. The bench therefore resets the block before each of all 256 lock-byte values. It applies that value to every lock byte, both as separate byte writes and as one 32-bit write. It reads the lock word back and then tries to clear it. Locked-byte suppression and mirror-window locking are reached by setting locks first and then sweeping data writes of every size through both windows.

// File: rtl/wlock_pkg.sv
package wlock_pkg;

  typedef enum logic [1:0] {
    WIN_NONE = 2'd0,
    WIN_DATA = 2'd1,
    WIN_MIRR = 2'd2,
    WIN_LOCK = 2'd3
  } win_e;

  localparam logic [1:0] PC_NONE = 2'd0;
  localparam logic [1:0] PC_BYTE = 2'd1;
  localparam logic [1:0] PC_HALF = 2'd2;
  localparam logic [1:0] PC_WORD = 2'd3;

  function automatic logic [2:0] size_bytes(input logic [1:0] sz);
    case (sz)
      2'd0:    size_bytes = 3'd1;
      2'd1:    size_bytes = 3'd2;
      default: size_bytes = 3'd4;
    endcase
  endfunction

  function automatic logic [3:0] lane_mask(input logic [1:0] sz, input logic [1:0] lo);
    case (sz)
      2'd0:    lane_mask = 4'b0001 << lo;
      2'd1:    lane_mask = 4'b0011 << lo;
      default: lane_mask = 4'b1111;
    endcase
  endfunction

  // Lock bit that supplies enable/data for bit b under class pc
  function automatic int src_bit(input logic [1:0] pc, input int b);
    if (pc == PC_HALF)      src_bit = b & 2;
    else if (pc == PC_WORD) src_bit = 0;
    else                    src_bit = b;
  endfunction

endpackage

// File: rtl/wlock_decode.sv
module wlock_decode
  import wlock_pkg::*;
#(
  parameter int AW          = 16,
  parameter int NB          = 16,
  parameter int NL          = 4,
  parameter int MIRROR_BASE = 'h2000,
  parameter int LOCK_BASE   = 'h1000
) (
  input  logic [AW-1:0] addr,
  input  logic [1:0]    size,
  output logic          valid,
  output win_e          win,
  output logic [AW-3:0] widx,
  output logic [3:0]    be
);
  localparam logic [AW:0]   D_END  = (AW+1)'(NB);
  localparam logic [AW:0]   M_LO   = (AW+1)'(MIRROR_BASE);
  localparam logic [AW:0]   M_END  = (AW+1)'(MIRROR_BASE + NB);
  localparam logic [AW:0]   L_LO   = (AW+1)'(LOCK_BASE);
  localparam logic [AW:0]   L_END  = (AW+1)'(LOCK_BASE + NL);
  localparam logic [AW-1:0] M_OFS  = AW'(MIRROR_BASE);
  localparam logic [AW-1:0] L_OFS  = AW'(LOCK_BASE);

  logic [AW:0]   a_ext;
  logic [AW:0]   last;
  logic [AW-1:0] rel;
  logic          aligned;

  always_comb begin
    a_ext = {1'b0, addr};
    last  = a_ext + (AW+1)'(size_bytes(size)) - (AW+1)'(1);
    case (size)
      2'd0:    aligned = 1'b1;
      2'd1:    aligned = ~addr[0];
      2'd2:    aligned = (addr[1:0] == 2'b00);
      default: aligned = 1'b0;
    endcase
    win = WIN_NONE;
    rel = addr;
    if (last < D_END) begin
      win = WIN_DATA;
    end else if (a_ext >= M_LO && last < M_END) begin
      win = WIN_MIRR;
      rel = addr - M_OFS;
    end else if (a_ext >= L_LO && last < L_END) begin
      win = WIN_LOCK;
      rel = addr - L_OFS;
    end
    valid = aligned && (win != WIN_NONE);
    widx  = rel[AW-1:2];
    be    = lane_mask(size, rel[1:0]);
  end

endmodule

// File: rtl/wlock_regs.sv
module wlock_regs #(
  parameter int NB = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NB-1:0]   wen,
  input  logic [31:0]     wdata,
  output logic [8*NB-1:0] bytes_q
);
  for (genvar k = 0; k < NB; k++) begin : g_byte
    always_ff @(posedge clk) begin
      if (rst)         bytes_q[8*k +: 8] <= 8'h00;
      else if (wen[k]) bytes_q[8*k +: 8] <= wdata[8*(k%4) +: 8];
    end
  end
endmodule

// File: rtl/wlock_locks.sv
module wlock_locks
  import wlock_pkg::*;
#(
  parameter int          NB   = 16,
  parameter int          NL   = NB / 4,
  parameter logic [63:0] PROT = 64'h4AAAFF55
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NL-1:0] lwr,
  input  logic [31:0]   wdata,
  input  logic [NB-1:0] mset,
  output logic [NB-1:0] lock_q
);
  for (genvar j = 0; j < NL; j++) begin : g_reg
    logic [7:0] wd;
    assign wd = wdata[8*(j%4) +: 8];
    for (genvar b = 0; b < 4; b++) begin : g_bit
      localparam int         K   = 4*j + b;
      localparam logic [1:0] PC  = PROT[2*K +: 2];
      localparam int         SRC = src_bit(PC, b);
      if (PC == PC_NONE) begin : g_off
        assign lock_q[K] = 1'b0;
      end else begin : g_on
        logic set_n;
        assign set_n = (lwr[j] & wd[4+SRC] & wd[SRC]) | mset[K];
        always_ff @(posedge clk) begin
          if (rst)        lock_q[K] <= 1'b0;
          else if (set_n) lock_q[K] <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/wlock_guard.sv
module wlock_guard
  import wlock_pkg::*;
#(
  parameter int          AW          = 16,
  parameter int          NB          = 16,
  parameter int          MIRROR_BASE = 'h2000,
  parameter int          LOCK_BASE   = 'h1000,
  parameter logic [63:0] PROT        = 64'h4AAAFF55
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [1:0]    size,
  input  logic [31:0]   wdata,
  output logic          ack,
  output logic          err,
  output logic [31:0]   rdata
);
  localparam int NL  = NB / 4;
  localparam int WIX = AW - 2;

  logic            valid;
  win_e            win;
  logic [WIX-1:0]  widx;
  logic [3:0]      be;
  logic            data_win;
  logic [NB-1:0]   hit, wen, mset, lock_q;
  logic [NL-1:0]   lwr;
  logic [8*NB-1:0] bytes_q;
  logic            err_n;
  logic [31:0]     rd_n;

  wlock_decode #(
    .AW(AW), .NB(NB), .NL(NL), .MIRROR_BASE(MIRROR_BASE), .LOCK_BASE(LOCK_BASE)
  ) u_dec (
    .addr(addr), .size(size), .valid(valid), .win(win), .widx(widx), .be(be)
  );

  assign data_win = (win == WIN_DATA) || (win == WIN_MIRR);

  for (genvar k = 0; k < NB; k++) begin : g_hit
    localparam logic [1:0] PC = PROT[2*k +: 2];
    assign hit[k]  = req & we & valid & data_win &
                     (widx == WIX'(k/4)) & be[k%4];
    assign wen[k]  = hit[k] & ~lock_q[k];
    assign mset[k] = hit[k] & (win == WIN_MIRR) & (PC != PC_NONE);
  end

  for (genvar j = 0; j < NL; j++) begin : g_lwr
    assign lwr[j] = req & we & valid & (win == WIN_LOCK) &
                    (widx == WIX'(j/4)) & be[j%4];
  end

  wlock_regs #(.NB(NB)) u_regs (
    .clk(clk), .rst(rst), .wen(wen), .wdata(wdata), .bytes_q(bytes_q)
  );

  wlock_locks #(.NB(NB), .NL(NL), .PROT(PROT)) u_locks (
    .clk(clk), .rst(rst), .lwr(lwr), .wdata(wdata), .mset(mset), .lock_q(lock_q)
  );

  assign err_n = (req & ~valid) | (|(hit & lock_q));

  always_comb begin
    rd_n = '0;
    for (int k = 0; k < NB; k++) begin
      if (data_win && widx == WIX'(k/4) && be[k%4])
        rd_n[8*(k%4) +: 8] = bytes_q[8*k +: 8];
    end
    for (int j = 0; j < NL; j++) begin
      if (win == WIN_LOCK && widx == WIX'(j/4) && be[j%4])
        rd_n[8*(j%4) +: 8] = {4'b0000, lock_q[4*j +: 4]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ack   <= 1'b0;
      err   <= 1'b0;
      rdata <= '0;
    end else begin
      ack   <= req;
      err   <= err_n;
      rdata <= (req && !we && valid) ? rd_n : 32'h0;
    end
  end

endmodule

// File: rtl/wlock_guard_chk.sv
module wlock_guard_chk
  import wlock_pkg::*;
#(
  parameter int NB = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          req,
  input logic          we,
  input logic          valid,
  input logic [1:0]    win,
  input logic [NB-1:0] hit,
  input logic [NB-1:0] lock_q,
  input logic [NB-1:0] mset,
  input logic          ack,
  input logic          err
);
  p_ack_next_r2: assert property (@(posedge clk) disable iff (rst)
    req |=> ack);

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !req |=> (!ack && !err));

  p_normal_keeps_locks_r3: assert property (@(posedge clk) disable iff (rst)
    (req && we && valid && win == WIN_DATA) |=> (lock_q == $past(lock_q)));

  p_mirror_sets_r4: assert property (@(posedge clk) disable iff (rst)
    (req && we && valid && win == WIN_MIRR) |=> ((lock_q & $past(mset)) == $past(mset)));

  p_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    req |=> (($past(lock_q) & ~lock_q) == '0));

  p_locked_err_r11: assert property (@(posedge clk) disable iff (rst)
    (req && we && |(hit & lock_q)) |=> err);

  p_bad_err_r12: assert property (@(posedge clk) disable iff (rst)
    (req && !valid) |=> err);

  p_bad_keeps_locks_r12: assert property (@(posedge clk) disable iff (rst)
    (req && !valid) |=> (lock_q == $past(lock_q)));

endmodule

bind wlock_guard wlock_guard_chk #(.NB(NB)) u_chk (
  .clk(clk), .rst(rst), .req(req), .we(we), .valid(valid), .win(win),
  .hit(hit), .lock_q(lock_q), .mset(mset), .ack(ack), .err(err)
);

// File: tb/tb_wlock_guard.sv
`timescale 1ns/1ps
module tb_wlock_guard;
  localparam logic [63:0] PROT = 64'h4AAAFF55;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0;
  logic        we  = 1'b0;
  logic [15:0] addr = '0;
  logic [1:0]  size = '0;
  logic [31:0] wdata = '0;
  logic        ack, err;
  logic [31:0] rdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0]  m_mem [16];
  logic [15:0] m_lock;

  always #10 clk = ~clk;

  wlock_guard #(
    .AW(16), .NB(16), .MIRROR_BASE('h2000), .LOCK_BASE('h1000), .PROT(PROT)
  ) dut (
    .clk(clk), .rst(rst), .req(req), .we(we), .addr(addr), .size(size),
    .wdata(wdata), .ack(ack), .err(err), .rdata(rdata)
  );

  function automatic logic [1:0] pcls(input int k);
    return PROT[2*k +: 2];
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int k = 0; k < 16; k++) m_mem[k] = 8'h00;
    m_lock = '0;
  endtask

  task automatic reset_dut();
    @(negedge clk);
    rst = 1'b1;
    req = 1'b0;
    model_clear();
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // Apply a direct lock-byte write to the model per R6..R9
  task automatic model_lock_write(input int j, input logic [7:0] v);
    for (int b = 0; b < 4; b++) begin
      int k = 4*j + b;
      int s;
      logic [1:0] pc = pcls(k);
      s = (pc == 2'd2) ? (b & 2) : (pc == 2'd3) ? 0 : b;
      if (pc != 2'd0 && v[4+s] && v[s]) m_lock[k] = 1'b1;
    end
  endtask

  task automatic xfer(input logic w, input int a, input logic [1:0] sz,
                      input logic [31:0] wd, input string tag);
    int n, base, wn;
    logic ok, eerr;
    logic [31:0] erd;
    n  = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    ok = (sz != 2'd3) && ((a % n) == 0);
    wn = 0; base = 0;
    if (a + n <= 16) begin wn = 1; base = 0; end
    else if (a >= 'h2000 && a + n <= 'h2010) begin wn = 2; base = 'h2000; end
    else if (a >= 'h1000 && a + n <= 'h1004) begin wn = 3; base = 'h1000; end
    if (wn == 0) ok = 1'b0;
    erd = '0;
    eerr = !ok;
    if (ok) begin
      for (int i = 0; i < n; i++) begin
        int idx = a - base + i;
        if (!w) erd[8*(idx%4) +: 8] = (wn == 3) ? {4'b0, m_lock[4*idx +: 4]} : m_mem[idx];
        else if (wn != 3 && m_lock[idx]) eerr = 1'b1;
      end
    end
    @(negedge clk);
    req = 1'b1; we = w; addr = a[15:0]; size = sz; wdata = wd;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    chk({31'b0, ack}, 32'd1, {tag, " ack"});
    chk({31'b0, err}, {31'b0, eerr}, {tag, " err"});
    if (!w) chk(rdata, erd, {tag, " rdata"});
    if (ok && w) begin
      for (int i = 0; i < n; i++) begin
        int idx = a - base + i;
        logic [7:0] lb = wd[8*(idx%4) +: 8];
        if (wn == 3) model_lock_write(idx, lb);
        else begin
          if (!m_lock[idx]) m_mem[idx] = lb;
          if (wn == 2 && pcls(idx) != 2'd0) m_lock[idx] = 1'b1;
        end
      end
    end
  endtask

  task automatic read_all(input string tag);
    for (int a = 0; a < 16; a += 4) xfer(1'b0, a, 2'd2, 32'h0, tag);
    xfer(1'b0, 'h1000, 2'd2, 32'h0, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: idle outputs and cleared state
    chk({31'b0, ack}, 32'd0, "R1 ack idle");
    chk({31'b0, err}, 32'd0, "R1 err idle");
    read_all("R1");

    // R2 / R3: lane sweeps through the normal window, all sizes
    for (int a = 0; a < 16; a++) xfer(1'b1, a, 2'd0, 32'hA0B0C0D0 ^ {4{a[7:0]}}, "R2 wr8");
    for (int sz = 0; sz < 3; sz++)
      for (int a = 0; a < 16; a += (1 << sz)) begin
        xfer(1'b0, a, sz[1:0], 32'h0, "R2 rd");
        xfer(1'b0, 'h2000 + a, sz[1:0], 32'h0, "R13 mirror rd");
      end
    for (int a = 0; a < 16; a += 2) xfer(1'b1, a, 2'd1, 32'h1357_9BDF + a*32'h0101_0101, "R2 wr16");
    read_all("R2 after wr16");
    for (int a = 0; a < 16; a += 4) xfer(1'b1, a, 2'd2, 32'hC3A5_5A3C ^ (a * 32'h1111_1111), "R3 wr32");
    read_all("R3 no locks");

    // R12: illegal accesses change nothing
    xfer(1'b1, 'h0001, 2'd1, 32'hFFFF_FFFF, "R12 odd16");
    xfer(1'b1, 'h0002, 2'd2, 32'hFFFF_FFFF, "R12 mis32");
    xfer(1'b1, 'h0000, 2'd3, 32'hFFFF_FFFF, "R12 size3");
    xfer(1'b1, 'h0010, 2'd0, 32'hFFFF_FFFF, "R12 past data");
    xfer(1'b1, 'h2010, 2'd0, 32'hFFFF_FFFF, "R12 past mirror");
    xfer(1'b1, 'h1004, 2'd0, 32'hFFFF_FFFF, "R12 past lock");
    xfer(1'b1, 'h1001, 2'd1, 32'hFFFF_FFFF, "R12 odd lock");
    xfer(1'b1, 'h3000, 2'd2, 32'hFFFF_FFFF, "R12 hole");
    xfer(1'b0, 'h0fff, 2'd0, 32'h0, "R12 read hole");
    read_all("R12 unchanged");

    // R5..R10: every lock-byte value on every protection class
    for (int v = 0; v < 256; v++) begin
      reset_dut();
      for (int j = 0; j < 4; j++)
        xfer(1'b1, 'h1000 + j, 2'd0, 32'(v) << (8*j), "R6 R7 R8 R9 lock wr");
      xfer(1'b0, 'h1000, 2'd2, 32'h0, "R5 R6 R7 R8 R9 lock rd");
      xfer(1'b1, 'h1000, 2'd2, 32'hF0F0_F0F0, "R10 clear try");
      xfer(1'b0, 'h1000, 2'd2, 32'h0, "R10 sticky rd");
      reset_dut();
      xfer(1'b1, 'h1000, 2'd2, {4{v[7:0]}}, "R5 lock wr32");
      xfer(1'b0, 'h1000, 2'd2, 32'h0, "R5 R7 R8 lock rd32");
    end

    // R11: writes into locked bytes are suppressed with err
    reset_dut();
    for (int a = 0; a < 16; a += 4) xfer(1'b1, a, 2'd2, 32'h5566_7788 + a, "R11 preload");
    xfer(1'b1, 'h1000, 2'd2, 32'h9AF1_1135, "R11 set locks");
    for (int a = 0; a < 16; a += 4) xfer(1'b1, a, 2'd2, 32'hDEAD_BEEF, "R11 wr32");
    for (int a = 0; a < 16; a++) xfer(1'b1, a, 2'd0, {4{8'h3C ^ a[7:0]}}, "R11 wr8");
    for (int a = 0; a < 16; a += 2) xfer(1'b1, 'h2000 + a, 2'd1, 32'h0F0F_0F0F, "R11 mirror wr16");
    read_all("R11 readback");

    // R4: mirror writes lock protected bytes, byte by byte
    reset_dut();
    for (int a = 0; a < 16; a++) begin
      xfer(1'b1, 'h2000 + a, 2'd0, {4{a[7:0] + 8'h80}}, "R4 mirror wr8");
      xfer(1'b0, 'h1000, 2'd2, 32'h0, "R4 lock rd");
    end
    for (int a = 0; a < 16; a++) xfer(1'b1, a, 2'd0, 32'hFFFF_FFFF, "R4 R11 rewrite");
    read_all("R4 data");
    reset_dut();
    xfer(1'b1, 'h2008, 2'd1, 32'h0000_BBAA, "R4 mirror wr16");
    xfer(1'b1, 'h200C, 2'd2, 32'h4433_2211, "R4 mirror wr32 mixed");
    xfer(1'b1, 'h0004, 2'd2, 32'h7766_5544, "R3 normal wr32");
    read_all("R4 R3 after mirror");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule